// File: doc/BRIEF.md
# Multi-Size Translation Entry Matcher

This block keeps a small set of address translation entries and compares every one of them at once against a 32-bit virtual address. Each entry describes one page whose size is picked per entry from four choices, so the number of address bits taking part in the compare differs from entry to entry. An entry may belong to one address space, tagged by an 8-bit space identifier, or be marked as global so that it serves every address space.

A lookup is purely combinational. From the lookup address, the current space identifier and two mode inputs (a single-address-space flag and a privileged-mode flag), the block reports a single hit with the entry's index and stored payload (physical page number, protection bits, dirty bit), a miss, or a multiple-hit error. Entries are loaded one per clock through a write port addressed by entry index. Permission checks and fault generation are left to the surrounding logic.

Top module: `multisize_tlb_match`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss until an entry is loaded.
- R2: An entry whose valid bit is 0 never takes part in a match, whatever its other fields hold.
- R3: The size code picks the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB, 3 is 1 MB. An entry covers the addresses from its base, which is the stored VPN placed at bit 10 and upward with the bits below the page size cleared, through base plus page size minus 1, both ends included.
- R4: While space checking is on, an entry whose space identifier differs from `curAsid` is passed over, unless its global bit is 1.
- R5: Space checking is on only when `singleVirt` is 0 and `privMode` is 0; in every other combination the space identifiers play no part in matching.
- R6: When exactly one entry matches, `hit` is 1 and `hitIdx`, `hitPpn`, `hitProt` and `hitDirty` give that entry's index and stored payload.
- R7: When no entry matches, `miss` is 1 and `hit` and `multiHit` are 0.
- R8: When two or more entries match, `multiHit` is 1 and `hit` and `miss` are 0.
- R9: A write with `wrEn` at 1 replaces the entry at `wrIdx` on the rising clock edge; a lookup in the same cycle still sees the old entry and a lookup in the following cycle sees the new one. Lookup results follow the address and mode inputs in the same cycle.
- R10: Exactly one of `hit`, `miss` and `multiHit` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load the entry selected by `wrIdx` |
| wrIdx | input | IDX_W | Index of the entry to load |
| wrValid | input | 1 | Valid bit written into the entry |
| wrAsid | input | 8 | Space identifier written into the entry |
| wrShared | input | 1 | Global bit written into the entry |
| wrSize | input | 2 | Size code written into the entry |
| wrVpn | input | 22 | Virtual page number written into the entry |
| wrPpn | input | PPN_W | Physical page number written into the entry |
| wrProt | input | PROT_W | Protection bits written into the entry |
| wrDirty | input | 1 | Dirty bit written into the entry |
| curAsid | input | 8 | Current space identifier |
| singleVirt | input | 1 | Single-address-space mode; 1 turns space checking off |
| privMode | input | 1 | Privileged mode; 1 turns space checking off |
| lookupAddr | input | 32 | Virtual address being looked up |
| hit | output | 1 | Exactly one entry matches |
| miss | output | 1 | No entry matches |
| multiHit | output | 1 | More than one entry matches |
| hitIdx | output | IDX_W | Lowest matching index; 0 on a miss |
| hitPpn | output | PPN_W | Physical page number of the matching entry |
| hitProt | output | PROT_W | Protection bits of the matching entry |
| hitDirty | output | 1 | Dirty bit of the matching entry |

## Verification
The bench builds the matcher with four entries, which keeps every index, every size code and all sixteen combinations of mode, global bit and identifier agreement within a short run. With four entries it can stack one page inside another to provoke double and triple matches and still give each entry its own region for the index checks. Every size is swept at both edges of its range and one step past each edge, with the expected outcome worked out from the base and page size as plain integers.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 10;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int ASID_W     = 8;

  typedef enum logic [1:0] {
    SZ_1K  = 2'd0,
    SZ_4K  = 2'd1,
    SZ_64K = 2'd2,
    SZ_1M  = 2'd3
  } pageSize_e;

  // Tag half of an entry: the fields that take part in matching.
  typedef struct packed {
    logic              valid;
    logic [ASID_W-1:0] asid;
    logic              shared;
    pageSize_e         size;
    logic [VPN_W-1:0]  vpn;
  } entryTag_t;

  // Strobes from control to the entry array.
  typedef struct packed {
    logic loadEn;
    logic asidChk;
  } ctrlStrobe_t;

  function automatic int offsetBits(pageSize_e sz);
    case (sz)
      SZ_1K:   return PAGE_SHIFT;
      SZ_4K:   return PAGE_SHIFT + 2;
      SZ_64K:  return PAGE_SHIFT + 6;
      default: return PAGE_SHIFT + 10;
    endcase
  endfunction

  // Mask of the address bits above the page offset.
  function automatic logic [VA_W-1:0] pageMask(pageSize_e sz);
    return {VA_W{1'b1}} << offsetBits(sz);
  endfunction

endpackage

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
  import tlbm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             singleVirt,
  input  logic             privMode,
  output ctrlStrobe_t      strobe
);

  logic loadEn;

  // An index beyond the last entry is dropped; only needed when the
  // entry count leaves unused index codes.
  generate
    if (NUM_ENTRIES == (1 << IDX_W)) begin : gFullIdx
      assign loadEn = wrEn;
    end else begin : gPartIdx
      assign loadEn = wrEn && (int'(wrIdx) < NUM_ENTRIES);
    end
  endgenerate

  // R5: identifiers count only for an unprivileged, multi-space context
  assign strobe.loadEn  = loadEn;
  assign strobe.asidChk = !singleVirt && !privMode;

endmodule

// File: rtl/tlbm_array.sv
module tlbm_array
  import tlbm_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4,
  parameter int PPN_W       = 19,
  parameter int PROT_W      = 2
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctrlStrobe_t                         strobe,
  input  logic [IDX_W-1:0]                    wrIdx,
  input  entryTag_t                           wrTag,
  input  logic [PPN_W-1:0]                    wrPpn,
  input  logic [PROT_W-1:0]                   wrProt,
  input  logic                                wrDirty,
  input  logic [ASID_W-1:0]                   curAsid,
  input  logic [VA_W-1:0]                     lookupAddr,
  output logic [NUM_ENTRIES-1:0]              matchVec,
  output logic [NUM_ENTRIES-1:0][PPN_W-1:0]   entPpn,
  output logic [NUM_ENTRIES-1:0][PROT_W-1:0]  entProt,
  output logic [NUM_ENTRIES-1:0]              entDirty
);

  generate
    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : gEntry
      entryTag_t          tagQ;
      logic [PPN_W-1:0]   ppnQ;
      logic [PROT_W-1:0]  protQ;
      logic               dirtyQ;
      logic               selThis;
      logic [VA_W-1:0]    baseAddr;
      logic [VA_W-1:0]    cmpMask;
      logic               asidOk;
      logic               rangeOk;

      assign selThis = strobe.loadEn && (wrIdx == IDX_W'(i));

      // R1, R9: cleared by reset, replaced on the edge after a write
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tagQ   <= '0;
          ppnQ   <= '0;
          protQ  <= '0;
          dirtyQ <= 1'b0;
        end else if (selThis) begin
          tagQ   <= wrTag;
          ppnQ   <= wrPpn;
          protQ  <= wrProt;
          dirtyQ <= wrDirty;
        end
      end

      // R3: compare only the bits above this entry's page offset
      assign baseAddr = {tagQ.vpn, {PAGE_SHIFT{1'b0}}};
      assign cmpMask  = pageMask(tagQ.size);
      assign rangeOk  = ((lookupAddr ^ baseAddr) & cmpMask) == '0;

      // R4: a global entry or an equal identifier passes the space test
      assign asidOk   = !strobe.asidChk || tagQ.shared || (tagQ.asid == curAsid);

      // R2: the valid bit gates everything
      assign matchVec[i] = tagQ.valid && asidOk && rangeOk;
      assign entPpn[i]   = ppnQ;
      assign entProt[i]  = protQ;
      assign entDirty[i] = dirtyQ;
    end
  endgenerate

endmodule

// File: rtl/tlbm_resolve.sv
module tlbm_resolve #(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4,
  parameter int PPN_W       = 19,
  parameter int PROT_W      = 2
) (
  input  logic [NUM_ENTRIES-1:0]              matchVec,
  input  logic [NUM_ENTRIES-1:0][PPN_W-1:0]   entPpn,
  input  logic [NUM_ENTRIES-1:0][PROT_W-1:0]  entProt,
  input  logic [NUM_ENTRIES-1:0]              entDirty,
  output logic                                hit,
  output logic                                miss,
  output logic                                multiHit,
  output logic [IDX_W-1:0]                    hitIdx,
  output logic [PPN_W-1:0]                    hitPpn,
  output logic [PROT_W-1:0]                   hitProt,
  output logic                                hitDirty
);

  logic             anyMatch;
  logic             extraMatch;
  logic [IDX_W-1:0] firstIdx;

  // Lowest-index priority scan; a second match flags the duplicate.
  always_comb begin
    anyMatch   = 1'b0;
    extraMatch = 1'b0;
    firstIdx   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (matchVec[i]) begin
        if (anyMatch) begin
          extraMatch = 1'b1;
        end else begin
          anyMatch = 1'b1;
          firstIdx = IDX_W'(i);
        end
      end
    end
  end

  // R6, R7, R8: one of three outcomes
  assign hit      = anyMatch && !extraMatch;
  assign miss     = !anyMatch;
  assign multiHit = extraMatch;
  assign hitIdx   = firstIdx;

  assign hitPpn   = hit ? entPpn[firstIdx]   : '0;
  assign hitProt  = hit ? entProt[firstIdx]  : '0;
  assign hitDirty = hit ? entDirty[firstIdx] : 1'b0;

endmodule

// File: rtl/multisize_tlb_match.sv
module multisize_tlb_match
  import tlbm_pkg::*;
#(
  parameter  int NUM_ENTRIES = 16,
  parameter  int PPN_W       = 19,
  parameter  int PROT_W      = 2,
  localparam int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrValid,
  input  logic [ASID_W-1:0] wrAsid,
  input  logic              wrShared,
  input  logic [1:0]        wrSize,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PPN_W-1:0]  wrPpn,
  input  logic [PROT_W-1:0] wrProt,
  input  logic              wrDirty,
  input  logic [ASID_W-1:0] curAsid,
  input  logic              singleVirt,
  input  logic              privMode,
  input  logic [VA_W-1:0]   lookupAddr,
  output logic              hit,
  output logic              miss,
  output logic              multiHit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [PPN_W-1:0]  hitPpn,
  output logic [PROT_W-1:0] hitProt,
  output logic              hitDirty
);

  ctrlStrobe_t                        strobe;
  entryTag_t                          wrTag;
  logic [NUM_ENTRIES-1:0]             matchVec;
  logic [NUM_ENTRIES-1:0][PPN_W-1:0]  entPpn;
  logic [NUM_ENTRIES-1:0][PROT_W-1:0] entProt;
  logic [NUM_ENTRIES-1:0]             entDirty;

  assign wrTag.valid  = wrValid;
  assign wrTag.asid   = wrAsid;
  assign wrTag.shared = wrShared;
  assign wrTag.size   = pageSize_e'(wrSize);
  assign wrTag.vpn    = wrVpn;

  tlbm_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W)
  ) uCtrl (
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .singleVirt(singleVirt),
    .privMode  (privMode),
    .strobe    (strobe)
  );

  tlbm_array #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W),
    .PPN_W      (PPN_W),
    .PROT_W     (PROT_W)
  ) uArray (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrIdx     (wrIdx),
    .wrTag     (wrTag),
    .wrPpn     (wrPpn),
    .wrProt    (wrProt),
    .wrDirty   (wrDirty),
    .curAsid   (curAsid),
    .lookupAddr(lookupAddr),
    .matchVec  (matchVec),
    .entPpn    (entPpn),
    .entProt   (entProt),
    .entDirty  (entDirty)
  );

  tlbm_resolve #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .IDX_W      (IDX_W),
    .PPN_W      (PPN_W),
    .PROT_W     (PROT_W)
  ) uResolve (
    .matchVec(matchVec),
    .entPpn  (entPpn),
    .entProt (entProt),
    .entDirty(entDirty),
    .hit     (hit),
    .miss    (miss),
    .multiHit(multiHit),
    .hitIdx  (hitIdx),
    .hitPpn  (hitPpn),
    .hitProt (hitProt),
    .hitDirty(hitDirty)
  );

endmodule

// File: rtl/tlbm_checker.sv
module tlbm_checker #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             wrValid,
  input logic [IDX_W-1:0] wrIdx,
  input logic [31:0]      lookupAddr,
  input logic [7:0]       curAsid,
  input logic             singleVirt,
  input logic             privMode,
  input logic             hit,
  input logic             miss,
  input logic             multiHit,
  input logic [IDX_W-1:0] hitIdx
);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hit, miss, multiHit}) == 1);

  // R1
  reset_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> miss);

  // R2
  invalidated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && !wrValid) |-> !(hit && hitIdx == $past(wrIdx)));

  // R9
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(wrEn) && $stable(lookupAddr) && $stable(curAsid)
     && $stable(singleVirt) && $stable(privMode))
    |-> ($stable(hit) && $stable(miss) && $stable(multiHit) && $stable(hitIdx)));

endmodule

bind multisize_tlb_match tlbm_checker #(.IDX_W(IDX_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrValid   (wrValid),
  .wrIdx     (wrIdx),
  .lookupAddr(lookupAddr),
  .curAsid   (curAsid),
  .singleVirt(singleVirt),
  .privMode  (privMode),
  .hit       (hit),
  .miss      (miss),
  .multiHit  (multiHit),
  .hitIdx    (hitIdx)
);

// File: tb/multisize_tlb_match_test.sv
module multisize_tlb_match_test;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic        wrValid = 1'b0;
  logic [7:0]  wrAsid = '0;
  logic        wrShared = 1'b0;
  logic [1:0]  wrSize = '0;
  logic [21:0] wrVpn = '0;
  logic [18:0] wrPpn = '0;
  logic [1:0]  wrProt = '0;
  logic        wrDirty = 1'b0;
  logic [7:0]  curAsid = '0;
  logic        singleVirt = 1'b0;
  logic        privMode = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic        hit, miss, multiHit, hitDirty;
  logic [1:0]  hitIdx, hitProt;
  logic [18:0] hitPpn;

  multisize_tlb_match #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
    .wrAsid(wrAsid), .wrShared(wrShared), .wrSize(wrSize), .wrVpn(wrVpn),
    .wrPpn(wrPpn), .wrProt(wrProt), .wrDirty(wrDirty), .curAsid(curAsid),
    .singleVirt(singleVirt), .privMode(privMode), .lookupAddr(lookupAddr),
    .hit(hit), .miss(miss), .multiHit(multiHit), .hitIdx(hitIdx),
    .hitPpn(hitPpn), .hitProt(hitProt), .hitDirty(hitDirty)
  );

  always #2 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  bit          mValid [N];
  logic [7:0]  mAsid  [N];
  bit          mSh    [N];
  logic [1:0]  mSz    [N];
  logic [21:0] mVpn   [N];
  logic [18:0] mPpn   [N];
  logic [1:0]  mProt  [N];
  bit          mDirty [N];

  function automatic longint pageBytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 1024;
      2'd1:    return 4096;
      2'd2:    return 65536;
      default: return 1048576;
    endcase
  endfunction

  function automatic longint regionLo(int i);
    longint raw = longint'(mVpn[i]) * 1024;
    return (raw / pageBytes(mSz[i])) * pageBytes(mSz[i]);
  endfunction

  task automatic wrEntry(int idx, bit v, logic [7:0] a, bit sh, logic [1:0] sz,
                         logic [21:0] vpn, logic [18:0] ppn, logic [1:0] pr, bit d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx[1:0]; wrValid = v; wrAsid = a; wrShared = sh;
    wrSize = sz; wrVpn = vpn; wrPpn = ppn; wrProt = pr; wrDirty = d;
    @(negedge clk);
    wrEn = 1'b0;
    mValid[idx] = v; mAsid[idx] = a; mSh[idx] = sh; mSz[idx] = sz;
    mVpn[idx] = vpn; mPpn[idx] = ppn; mProt[idx] = pr; mDirty[idx] = d;
  endtask

  task automatic clearAll();
    for (int i = 0; i < N; i++) wrEntry(i, 0, 8'h00, 0, 2'd0, 22'h0, 19'h0, 2'd0, 0);
  endtask

  // Compare current outputs with the model (caller has already set inputs)
  task automatic compareNow(string tag);
    int cnt = 0;
    int first = -1;
    bit chk = !singleVirt && !privMode;
    bit eHit, eMiss, eMulti, bad;
    for (int i = 0; i < N; i++) begin
      longint lo = regionLo(i);
      longint hi = lo + pageBytes(mSz[i]) - 1;
      bit asidOk = !chk || mSh[i] || (mAsid[i] == curAsid);
      if (mValid[i] && asidOk && longint'(lookupAddr) >= lo && longint'(lookupAddr) <= hi) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    eHit = (cnt == 1); eMiss = (cnt == 0); eMulti = (cnt > 1);
    bad = (hit !== eHit) || (miss !== eMiss) || (multiHit !== eMulti);
    if (!bad && eHit)
      bad = (int'(hitIdx) != first) || (hitPpn !== mPpn[first]) ||
            (hitProt !== mProt[first]) || (hitDirty !== mDirty[first]);
    nChecks++;
    if (bad) begin
      nFail++;
      $display("FAIL %s addr=%h got hit=%b miss=%b multi=%b idx=%0d ppn=%h prot=%b d=%b expected hit=%b miss=%b multi=%b idx=%0d",
               tag, lookupAddr, hit, miss, multiHit, hitIdx, hitPpn, hitProt, hitDirty,
               eHit, eMiss, eMulti, first);
    end
    // R10: exactly one outcome flag
    nChecks++;
    if ($countones({hit, miss, multiHit}) != 1) begin
      nFail++;
      $display("FAIL R10 addr=%h got flags=%b%b%b expected one set", lookupAddr, hit, miss, multiHit);
    end
  endtask

  task automatic lookup(logic [31:0] addr, string tag);
    @(negedge clk);
    lookupAddr = addr;
    #1;
    compareNow(tag);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mAsid[i] = '0; mSh[i] = 0; mSz[i] = '0;
      mVpn[i] = '0; mPpn[i] = '0; mProt[i] = '0; mDirty[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: nothing matches after reset
    lookup(32'h0000_0000, "R1");
    lookup(32'h1234_5400, "R1");
    lookup(32'hFFFF_FFFF, "R1");

    // R3: each size at both edges and one step past them
    for (int sz = 0; sz < 4; sz++) begin
      for (int v = 0; v < 4; v++) begin
        logic [21:0] vpn;
        longint lo, sizeB;
        case (v)
          0: vpn = 22'h000000;
          1: vpn = 22'h0ABCDE;
          2: vpn = 22'h3FFFFF;
          default: vpn = 22'h012345;
        endcase
        clearAll();
        wrEntry(1, 1, 8'h11, 1, sz[1:0], vpn, 19'h5A5A5 + 19'(sz * 4 + v), sz[1:0], v[0]);
        sizeB = pageBytes(sz[1:0]);
        lo = regionLo(1);
        lookup(32'(lo - 1), "R3");
        lookup(32'(lo), "R3");
        lookup(32'(lo + sizeB / 2), "R3");
        lookup(32'(lo + sizeB - 1), "R3");
        lookup(32'(lo + sizeB), "R3");
        lookup({vpn, 10'h3FF}, "R3");
      end
    end

    // R2: an invalid entry never matches; validation then re-invalidation
    clearAll();
    wrEntry(2, 0, 8'h00, 1, 2'd1, 22'h004000, 19'h00123, 2'd3, 1);
    lookup(32'h0100_0010, "R2");
    wrEntry(2, 1, 8'h00, 1, 2'd1, 22'h004000, 19'h00123, 2'd3, 1);
    lookup(32'h0100_0010, "R2");
    wrEntry(2, 0, 8'h00, 1, 2'd1, 22'h004000, 19'h00123, 2'd3, 1);
    lookup(32'h0100_0010, "R2");

    // R4 / R5: all mode, global-bit and identifier combinations
    clearAll();
    for (int c = 0; c < 16; c++) begin
      bit pm = c[0], sv = c[1], sh = c[2], same = c[3];
      wrEntry(0, 1, 8'h5A, sh, 2'd1, 22'h00C000, 19'h0ABCD, 2'd1, 0);
      @(negedge clk);
      privMode = pm; singleVirt = sv; curAsid = same ? 8'h5A : 8'hA5;
      if (!pm && !sv) lookup(32'h0300_0123, "R4");
      else            lookup(32'h0300_0123, "R5");
    end
    privMode = 1'b0; singleVirt = 1'b0; curAsid = 8'h00;

    // R8: nested pages give double and triple matches
    clearAll();
    wrEntry(0, 1, 8'h00, 1, 2'd3, 22'h040000, 19'h00100, 2'd2, 1);
    wrEntry(3, 1, 8'h00, 1, 2'd1, 22'h0400D0, 19'h00200, 2'd1, 0);
    lookup(32'h1003_4010, "R8");
    lookup(32'h1005_0000, "R6");
    wrEntry(2, 1, 8'h00, 1, 2'd0, 22'h0400D0, 19'h00300, 2'd0, 1);
    lookup(32'h1003_4010, "R8");
    lookup(32'h1003_4800, "R8");
    lookup(32'h1010_0000, "R7");

    // R6: every index in its own region
    clearAll();
    for (int i = 0; i < N; i++)
      wrEntry(i, 1, 8'h00, 1, 2'd0, 22'h000100 + 22'(i * 3), 19'h10000 + 19'(i), 2'(i), i[0]);
    for (int i = 0; i < N; i++) begin
      lookup({22'h000100 + 22'(i * 3), 10'h000}, "R6");
      lookup({22'h000100 + 22'(i * 3), 10'h2AB}, "R6");
    end
    // R7: between and beyond the regions
    lookup({22'h000101, 10'h000}, "R7");
    lookup(32'h8000_0000, "R7");

    // R9: write is not seen in its own cycle, and is seen in the next
    clearAll();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 2'd2; wrValid = 1'b1; wrAsid = 8'h00; wrShared = 1'b1;
    wrSize = 2'd2; wrVpn = 22'h010040; wrPpn = 19'h07777; wrProt = 2'd3; wrDirty = 1'b1;
    lookupAddr = 32'h0401_2345;
    #1;
    compareNow("R9");
    @(negedge clk);
    wrEn = 1'b0;
    mValid[2] = 1; mAsid[2] = 8'h00; mSh[2] = 1; mSz[2] = 2'd2;
    mVpn[2] = 22'h010040; mPpn[2] = 19'h07777; mProt[2] = 2'd3; mDirty[2] = 1;
    #1;
    compareNow("R9");
    nChecks++;
    if (hit !== 1'b1) begin
      nFail++;
      $display("FAIL R9 got hit=%b expected hit=1 one cycle after write", hit);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule